// File: doc/BRIEF.md
# Security interrupt aggregator

This block gathers the security-violation interrupt lines of a subsystem into one register-mapped place. It samples level status from three families of sources: memory protection controllers, peripheral protection controllers and master security controllers. Each family has its own status word, with bits at fixed, sparse positions. Software reads these words through a 32-bit word register port.

Interrupts from peripheral protection controllers are cleared by a write-one-to-clear register. The write removes the bits from the local status and sends each controller's status bit back on a clear line. Each controller also receives its enable bit on an enable line. For master security controllers, a clear write drives the written value straight onto the clear lines of those sources. The block raises one registered combined interrupt whenever a master security status bit is set and its enable bit is also set. A bridge error group is present in the map, but its status is tied to zero. Only its enable register holds state.

Top module: `secirq_agg`

## Requirements
- R1: In reset and right after it, every status word, every enable word and the bridge enable word read 0, and `ppc_clr_o`, `ppc_en_o`, `msc_clr_o` and `msc_irq_o` are all 0.
- R2: The word at offset 0x00 reflects the memory protection inputs one clock after they are applied. Internal input i sits at bit i and expansion input j sits at bit 16+j. All other bits read 0.
- R3: The peripheral protection status word at offset 0x04 places controller k of `ppc_irq_i` at a fixed bit. The order of k is internal APB first, then APB expansion, then AHB expansion. With the default sizes, k = 0..9 map to bits 0, 1, 4, 5, 6, 7, 20, 21, 22, 23. A status bit takes the input's new value on the clock after that input changes.
- R4: A full write to offset 0x08 clears the status bits selected by the written value. A cleared bit stays 0 while its input is held steady, and is set again once the input falls and rises. On each write to 0x08 or 0x0C, `ppc_clr_o[k]` loads controller k's status bit as it stands after that write.
- R5: The enable word at offset 0x0C keeps only the mapped controller bits, which is 0x00F000F3 by default, and reads them back. `ppc_en_o[k]` equals controller k's enable bit.
- R6: The master security status word at offset 0x10 holds input i at bit 16+i. A full write to offset 0x14 drives bit 16+i of the written value onto `msc_clr_o[i]`, and that value holds until the next such write.
- R7: `msc_irq_o` is high when the status word at 0x10 AND the enable word at 0x18 is nonzero. It changes on the clock after a change in either of them.
- R8: The bridge status word at 0x1C always reads 0. A write to the bridge clear word at 0x20 has no effect. The bridge enable word at 0x24 keeps only bits 31:16.
- R9: The clear words at 0x08 and 0x14 read 0. Writes to the status words at 0x00, 0x04 and 0x10 change nothing. Unmapped or unaligned offsets read 0.
- R10: A write whose byte lanes `reg_be` are not all set is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_we | input | 1 | Write enable |
| reg_be | input | 4 | Byte lanes of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mpc_int_i | input | N_MPC_INT | Internal memory protection interrupt levels |
| mpc_exp_i | input | N_MPC_EXP | Expansion memory protection interrupt levels |
| ppc_irq_i | input | N_APB+N_APBX+N_AHBX | Peripheral protection interrupt levels |
| ppc_clr_o | output | N_APB+N_APBX+N_AHBX | Clear line per peripheral protection controller |
| ppc_en_o | output | N_APB+N_APBX+N_AHBX | Enable line per peripheral protection controller |
| msc_irq_i | input | N_MSC | Master security interrupt levels |
| msc_clr_o | output | N_MSC | Clear line per master security controller |
| msc_irq_o | output | 1 | Combined master security interrupt |

## Verification
The bench places every peripheral protection controller at its sparse bit. If the index-to-bit mapping were wrong, the status or enable word would show a bit at the wrong position or the wrong enable line would be set. It clears a status bit while the input stays high and confirms that the bit does not return. A design that made the status sticky or level-following would set the bit again at once. It then toggles the input to show the bit does come back after a fresh change. Further checks time the combined interrupt to the exact clock after an enable write and after a status drop, which would catch an output that is combinational or delayed by two stages. Partial-lane writes, writes to status words and writes to the bridge clear word are each followed by a read-back of the state they could have corrupted.

// File: rtl/secirq_pkg.sv
package secirq_pkg;

   localparam int DATA_W = 32;

   // byte offsets of the register words
   localparam int OFS_MPC_STAT = 'h00;
   localparam int OFS_PPC_STAT = 'h04;
   localparam int OFS_PPC_CLR  = 'h08;
   localparam int OFS_PPC_EN   = 'h0C;
   localparam int OFS_MSC_STAT = 'h10;
   localparam int OFS_MSC_CLR  = 'h14;
   localparam int OFS_MSC_EN   = 'h18;
   localparam int OFS_BRG_STAT = 'h1C;
   localparam int OFS_BRG_CLR  = 'h20;
   localparam int OFS_BRG_EN   = 'h24;

   // fixed base bit of each source group
   localparam int MPC_EXP_BASE = 16;
   localparam int PPC_APBX_BASE = 4;
   localparam int PPC_AHBX_BASE = 20;
   localparam int MSC_BASE      = 16;
   localparam logic [DATA_W-1:0] BRG_EN_KEEP = 32'hFFFF_0000;

   typedef struct packed {
      logic ppc_clr;
      logic ppc_en;
      logic msc_clr;
      logic msc_en;
      logic brg_en;
   } wr_strobe_t;

   // status bit position of flat peripheral controller index k
   function automatic int ppc_pos(input int k, input int n_apb, input int n_apbx);
      if (k < n_apb) return k;
      if (k < n_apb + n_apbx) return PPC_APBX_BASE + k - n_apb;
      return PPC_AHBX_BASE + k - n_apb - n_apbx;
   endfunction

   function automatic logic [DATA_W-1:0] ppc_mask(input int n_apb, input int n_apbx,
                                                  input int n_ahbx);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int k = 0; k < n_apb + n_apbx + n_ahbx; k++) m[ppc_pos(k, n_apb, n_apbx)] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/secirq_regport.sv
module secirq_regport
   import secirq_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [3:0]        reg_be,
   input  logic [DATA_W-1:0] mpc_word,
   input  logic [DATA_W-1:0] ppc_stat_word,
   input  logic [DATA_W-1:0] ppc_en_word,
   input  logic [DATA_W-1:0] msc_stat_word,
   input  logic [DATA_W-1:0] msc_en_word,
   input  logic [DATA_W-1:0] brg_en_word,
   output wr_strobe_t        stb,
   output logic [DATA_W-1:0] rdata
);

   logic wr_full;

   function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   // only whole-word writes are accepted
   assign wr_full = reg_we && (reg_be == 4'hF);

   always_comb begin
      stb.ppc_clr = wr_full && at(reg_addr, OFS_PPC_CLR);
      stb.ppc_en  = wr_full && at(reg_addr, OFS_PPC_EN);
      stb.msc_clr = wr_full && at(reg_addr, OFS_MSC_CLR);
      stb.msc_en  = wr_full && at(reg_addr, OFS_MSC_EN);
      stb.brg_en  = wr_full && at(reg_addr, OFS_BRG_EN);
   end

   // clear words, bridge status and unmapped offsets fall through to zero
   always_comb begin
      rdata = '0;
      if (at(reg_addr, OFS_MPC_STAT)) rdata = mpc_word;
      if (at(reg_addr, OFS_PPC_STAT)) rdata = ppc_stat_word;
      if (at(reg_addr, OFS_PPC_EN))   rdata = ppc_en_word;
      if (at(reg_addr, OFS_MSC_STAT)) rdata = msc_stat_word;
      if (at(reg_addr, OFS_MSC_EN))   rdata = msc_en_word;
      if (at(reg_addr, OFS_BRG_EN))   rdata = brg_en_word;
   end

endmodule

// File: rtl/secirq_ppc_cell.sv
module secirq_ppc_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_i,
   input  logic clr_hit,
   input  logic en_wr,
   input  logic en_val,
   input  logic load_out,
   output logic stat_o,
   output logic en_o,
   output logic clr_o
);

   logic prev_q, stat_q, stat_d, en_q, clr_q;

   // an input edge updates status; a clear only acts on a quiet input
   always_comb begin
      stat_d = stat_q;
      if (irq_i != prev_q) stat_d = irq_i;
      else if (clr_hit)    stat_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         stat_q <= 1'b0;
         en_q   <= 1'b0;
         clr_q  <= 1'b0;
      end else begin
         prev_q <= irq_i;
         stat_q <= stat_d;
         if (en_wr)    en_q  <= en_val;
         if (load_out) clr_q <= stat_d;
      end
   end

   assign stat_o = stat_q;
   assign en_o   = en_q;
   assign clr_o  = clr_q;

endmodule

// File: rtl/secirq_msc_group.sv
module secirq_msc_group
   import secirq_pkg::*;
#(
   parameter int N_SRC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_i,
   input  logic              en_wr,
   input  logic              clr_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] stat_word,
   output logic [DATA_W-1:0] en_word,
   output logic [N_SRC-1:0]  clr_o,
   output logic              irq_o
);

   logic [N_SRC-1:0]  stat_q, clr_q;
   logic [DATA_W-1:0] en_q;
   logic              irq_q;

   always_comb begin
      stat_word = '0;
      stat_word[MSC_BASE +: N_SRC] = stat_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         clr_q  <= '0;
         en_q   <= '0;
         irq_q  <= 1'b0;
      end else begin
         stat_q <= irq_i;
         if (en_wr)  en_q  <= wdata;
         if (clr_wr) clr_q <= wdata[MSC_BASE +: N_SRC];
         irq_q <= |(stat_word & en_q);
      end
   end

   assign en_word = en_q;
   assign clr_o   = clr_q;
   assign irq_o   = irq_q;

endmodule

// File: rtl/secirq_agg.sv
module secirq_agg
   import secirq_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int N_MPC_INT = 2,
   parameter int N_MPC_EXP = 4,
   parameter int N_APB     = 2,
   parameter int N_APBX    = 4,
   parameter int N_AHBX    = 4,
   parameter int N_MSC     = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ADDR_W-1:0]              reg_addr,
   input  logic                           reg_we,
   input  logic [3:0]                     reg_be,
   input  logic [31:0]                    reg_wdata,
   output logic [31:0]                    reg_rdata,
   input  logic [N_MPC_INT-1:0]           mpc_int_i,
   input  logic [N_MPC_EXP-1:0]           mpc_exp_i,
   input  logic [N_APB+N_APBX+N_AHBX-1:0] ppc_irq_i,
   output logic [N_APB+N_APBX+N_AHBX-1:0] ppc_clr_o,
   output logic [N_APB+N_APBX+N_AHBX-1:0] ppc_en_o,
   input  logic [N_MSC-1:0]               msc_irq_i,
   output logic [N_MSC-1:0]               msc_clr_o,
   output logic                           msc_irq_o
);

   localparam int NPPC = N_APB + N_APBX + N_AHBX;
   localparam logic [DATA_W-1:0] PPC_MASK = ppc_mask(N_APB, N_APBX, N_AHBX);

   // elaboration-time range checks on the group sizes
   if (ADDR_W < 6 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 6..16");
   end
   if (N_MPC_INT < 1 || N_MPC_INT > MPC_EXP_BASE) begin : g_bad_mpc
      $error("N_MPC_INT must lie in 1..16");
   end
   if (N_MPC_EXP < 1 || N_MPC_EXP > DATA_W - MPC_EXP_BASE) begin : g_bad_mpcx
      $error("N_MPC_EXP must lie in 1..16");
   end
   if (N_APB < 1 || N_APB > PPC_APBX_BASE) begin : g_bad_apb
      $error("N_APB must lie in 1..4");
   end
   if (N_APBX < 1 || PPC_APBX_BASE + N_APBX > MSC_BASE) begin : g_bad_apbx
      $error("N_APBX must lie in 1..12");
   end
   if (N_AHBX < 1 || PPC_AHBX_BASE + N_AHBX > DATA_W) begin : g_bad_ahbx
      $error("N_AHBX must lie in 1..12");
   end
   if (N_MSC < 1 || N_MSC > DATA_W - MSC_BASE) begin : g_bad_msc
      $error("N_MSC must lie in 1..16");
   end

   wr_strobe_t        stb;
   logic [DATA_W-1:0] mpc_q, mpc_d;
   logic [DATA_W-1:0] ppc_stat_word, ppc_en_word;
   logic [DATA_W-1:0] msc_stat_word, msc_en_word;
   logic [DATA_W-1:0] brg_en_q;
   logic [NPPC-1:0]   ppc_stat;

   secirq_regport #(.ADDR_W(ADDR_W)) u_port (
      .reg_addr     (reg_addr),
      .reg_we       (reg_we),
      .reg_be       (reg_be),
      .mpc_word     (mpc_q),
      .ppc_stat_word(ppc_stat_word),
      .ppc_en_word  (ppc_en_word),
      .msc_stat_word(msc_stat_word),
      .msc_en_word  (msc_en_word),
      .brg_en_word  (brg_en_q),
      .stb          (stb),
      .rdata        (reg_rdata)
   );

   // memory protection status: plain level sampling
   always_comb begin
      mpc_d = '0;
      mpc_d[N_MPC_INT-1:0] = mpc_int_i;
      mpc_d[MPC_EXP_BASE +: N_MPC_EXP] = mpc_exp_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mpc_q    <= '0;
         brg_en_q <= '0;
      end else begin
         mpc_q <= mpc_d;
         if (stb.brg_en) brg_en_q <= reg_wdata & BRG_EN_KEEP;
      end
   end

   // one status cell per peripheral protection controller
   for (genvar k = 0; k < NPPC; k++) begin : g_ppc
      localparam int POS = ppc_pos(k, N_APB, N_APBX);
      secirq_ppc_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .irq_i   (ppc_irq_i[k]),
         .clr_hit (stb.ppc_clr && reg_wdata[POS]),
         .en_wr   (stb.ppc_en),
         .en_val  (reg_wdata[POS]),
         .load_out(stb.ppc_clr || stb.ppc_en),
         .stat_o  (ppc_stat[k]),
         .en_o    (ppc_en_o[k]),
         .clr_o   (ppc_clr_o[k])
      );
   end

   always_comb begin
      ppc_stat_word = '0;
      ppc_en_word   = '0;
      for (int k = 0; k < NPPC; k++) begin
         ppc_stat_word[ppc_pos(k, N_APB, N_APBX)] = ppc_stat[k];
         ppc_en_word[ppc_pos(k, N_APB, N_APBX)]   = ppc_en_o[k];
      end
      ppc_stat_word = ppc_stat_word & PPC_MASK;
      ppc_en_word   = ppc_en_word & PPC_MASK;
   end

   secirq_msc_group #(.N_SRC(N_MSC)) u_msc (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_i    (msc_irq_i),
      .en_wr    (stb.msc_en),
      .clr_wr   (stb.msc_clr),
      .wdata    (reg_wdata),
      .stat_word(msc_stat_word),
      .en_word  (msc_en_word),
      .clr_o    (msc_clr_o),
      .irq_o    (msc_irq_o)
   );

endmodule

// File: rtl/secirq_agg_chk.sv
module secirq_agg_chk #(
   parameter int ADDR_W = 8,
   parameter int NPPC   = 10,
   parameter int N_MSC  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_we,
   input logic [3:0]        reg_be,
   input logic [31:0]       reg_wdata,
   input logic [NPPC-1:0]   ppc_clr_o,
   input logic [NPPC-1:0]   ppc_en_o,
   input logic [N_MSC-1:0]  msc_irq_i,
   input logic [N_MSC-1:0]  msc_clr_o,
   input logic              msc_irq_o
);

   logic full_wr;
   assign full_wr = reg_we && (reg_be == 4'hF);

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (ppc_clr_o == '0 && ppc_en_o == '0 &&
                                  msc_clr_o == '0 && msc_irq_o == 1'b0)
            else $error("outputs not quiet in reset");
      end
   end

   // R5
   ppc_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_wr && reg_addr == ADDR_W'('h0C)) |=> $stable(ppc_en_o));

   // R4
   ppc_clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_wr && (reg_addr == ADDR_W'('h08) || reg_addr == ADDR_W'('h0C)))
      |=> $stable(ppc_clr_o));

   // R6
   msc_clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_wr && reg_addr == ADDR_W'('h14)) |=> $stable(msc_clr_o));

   // R6
   msc_clr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_wr && reg_addr == ADDR_W'('h14)) |=> msc_clr_o == $past(reg_wdata[16 +: N_MSC]));

   // R7
   msc_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msc_irq_o |-> $past(|msc_irq_i, 2));

   // R10
   partial_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_be != 4'hF) |=> ($stable(ppc_en_o) && $stable(ppc_clr_o) &&
                                      $stable(msc_clr_o)));

endmodule

bind secirq_agg secirq_agg_chk #(
   .ADDR_W(ADDR_W),
   .NPPC  (N_APB + N_APBX + N_AHBX),
   .N_MSC (N_MSC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_addr (reg_addr),
   .reg_we   (reg_we),
   .reg_be   (reg_be),
   .reg_wdata(reg_wdata),
   .ppc_clr_o(ppc_clr_o),
   .ppc_en_o (ppc_en_o),
   .msc_irq_i(msc_irq_i),
   .msc_clr_o(msc_clr_o),
   .msc_irq_o(msc_irq_o)
);

// File: tb/secirq_agg_tb.sv
`timescale 1ns/1ps
module secirq_agg_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_be = 4'hF;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  mpc_int_i = '0;
   logic [3:0]  mpc_exp_i = '0;
   logic [9:0]  ppc_irq_i = '0;
   logic [9:0]  ppc_clr_o, ppc_en_o;
   logic [3:0]  msc_irq_i = '0;
   logic [3:0]  msc_clr_o;
   logic        msc_irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   secirq_agg dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_be(reg_be),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mpc_int_i(mpc_int_i),
      .mpc_exp_i(mpc_exp_i), .ppc_irq_i(ppc_irq_i), .ppc_clr_o(ppc_clr_o),
      .ppc_en_o(ppc_en_o), .msc_irq_i(msc_irq_i), .msc_clr_o(msc_clr_o),
      .msc_irq_o(msc_irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_be = be; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_be = 4'hF;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      for (int a = 0; a <= 'h24; a += 4) begin
         rd(8'(a), v);
         check("R1 word in reset", v, 32'h0);
      end
      check("R1 outputs in reset", {ppc_clr_o, ppc_en_o, msc_clr_o, msc_irq_o}, 32'h0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check("R1 outputs after reset", {ppc_clr_o, ppc_en_o, msc_clr_o, msc_irq_o}, 32'h0);
   endtask

   task automatic t_mpc;
      logic [31:0] v;
      @(negedge clk) begin mpc_int_i = 2'b10; mpc_exp_i = 4'b0101; end
      rd(8'h00, v);
      check("R2 memory protection layout", v, 32'h0005_0002);
   endtask

   task automatic t_ppc_status;
      logic [31:0] v;
      @(negedge clk) ppc_irq_i = 10'h3FF;
      rd(8'h04, v);
      check("R3 all controllers set", v, 32'h00F0_00F3);
      @(negedge clk) ppc_irq_i = 10'b10_0000_0101;
      rd(8'h04, v);
      check("R3 sparse pattern k0 k2 k9", v, 32'h0080_0011);
   endtask

   task automatic t_ppc_clear;
      logic [31:0] v;
      wr(8'h08, 32'h0000_0010);
      check("R4 clear line after clear write", 32'(ppc_clr_o), 32'h201);
      rd(8'h04, v);
      check("R4 bit stays cleared under steady input", v, 32'h0080_0001);
      rd(8'h08, v);
      check("R9 clear word reads zero", v, 32'h0);
      @(negedge clk) ppc_irq_i[2] = 1'b0;
      @(negedge clk) ppc_irq_i[2] = 1'b1;
      rd(8'h04, v);
      check("R4 bit returns after new edge", v, 32'h0080_0011);
      check("R4 clear line holds without write", 32'(ppc_clr_o), 32'h201);
   endtask

   task automatic t_ppc_enable;
      logic [31:0] v;
      wr(8'h0C, 32'hFFFF_FFFF);
      rd(8'h0C, v);
      check("R5 enable mask", v, 32'h00F0_00F3);
      check("R5 enable lines all set", 32'(ppc_en_o), 32'h3FF);
      check("R4 clear line loads on enable write", 32'(ppc_clr_o), 32'h205);
      wr(8'h0C, 32'h0010_0002);
      rd(8'h0C, v);
      check("R5 enable readback", v, 32'h0010_0002);
      check("R5 enable lines k1 k6", 32'(ppc_en_o), 32'h042);
   endtask

   task automatic t_msc;
      logic [31:0] v;
      @(negedge clk) msc_irq_i = 4'b0110;
      rd(8'h10, v);
      check("R6 master security status layout", v, 32'h0006_0000);
      wr(8'h14, 32'h000A_0000);
      check("R6 clear lines", 32'(msc_clr_o), 32'hA);
      rd(8'h14, v);
      check("R9 master clear word reads zero", v, 32'h0);
      check("R6 clear lines hold", 32'(msc_clr_o), 32'hA);
   endtask

   task automatic t_irq;
      logic [31:0] v;
      check("R7 idle with enable zero", 32'(msc_irq_o), 32'h0);
      wr(8'h18, 32'h0004_0000);
      check("R7 not yet high in write cycle", 32'(msc_irq_o), 32'h0);
      @(negedge clk);
      check("R7 high one cycle after enable", 32'(msc_irq_o), 32'h1);
      msc_irq_i = 4'b0010;
      @(negedge clk);
      check("R7 still high while status updates", 32'(msc_irq_o), 32'h1);
      @(negedge clk);
      check("R7 low one cycle after status drop", 32'(msc_irq_o), 32'h0);
      rd(8'h18, v);
      check("R7 enable readback", v, 32'h0004_0000);
   endtask

   task automatic t_bridge;
      logic [31:0] v;
      rd(8'h1C, v);
      check("R8 bridge status zero", v, 32'h0);
      wr(8'h24, 32'hFFFF_FFFF);
      rd(8'h24, v);
      check("R8 bridge enable keeps top half", v, 32'hFFFF_0000);
      wr(8'h1C, 32'h0000_1234);
      rd(8'h1C, v);
      check("R8 bridge status ignores write", v, 32'h0);
      wr(8'h20, 32'hFFFF_FFFF);
      rd(8'h24, v);
      check("R8 bridge clear has no effect", v, 32'hFFFF_0000);
   endtask

   task automatic t_readonly;
      logic [31:0] v;
      wr(8'h04, 32'h0);
      rd(8'h04, v);
      check("R9 peripheral status ignores write", v, 32'h0080_0011);
      wr(8'h00, 32'h0);
      rd(8'h00, v);
      check("R9 memory status ignores write", v, 32'h0005_0002);
      wr(8'h10, 32'h0);
      rd(8'h10, v);
      check("R9 master status ignores write", v, 32'h0002_0000);
      rd(8'h40, v);
      check("R9 unmapped reads zero", v, 32'h0);
      rd(8'h0D, v);
      check("R9 unaligned reads zero", v, 32'h0);
   endtask

   task automatic t_partial;
      logic [31:0] v;
      wr(8'h0C, 32'h0, 4'h3);
      rd(8'h0C, v);
      check("R10 partial enable write ignored", v, 32'h0010_0002);
      check("R10 enable lines unchanged", 32'(ppc_en_o), 32'h042);
      wr(8'h14, 32'h0, 4'hE);
      check("R10 partial clear write ignored", 32'(msc_clr_o), 32'hA);
      wr(8'h24, 32'h0, 4'h7);
      rd(8'h24, v);
      check("R10 partial bridge write ignored", v, 32'hFFFF_0000);
   endtask

   initial begin
      t_reset();
      t_mpc();
      t_ppc_status();
      t_ppc_clear();
      t_ppc_enable();
      t_msc();
      t_irq();
      t_bridge();
      t_readonly();
      t_partial();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule